// File: doc/BRIEF.md
# Transmit Descriptor Error Handler

This block walks a ring of transmit descriptors on behalf of an Ethernet-style transmitter. For each descriptor it checks that the controller owns it and turns the stored byte count, which is held as a two's complement, into a buffer length. It then counts the bytes the data path pulls from that buffer. It gathers the error events seen while the frame is active and writes them back into the descriptor as sticky status bits. In the same write it clears the ownership bit, which returns the descriptor to the host.

A frame may span several descriptors. When a buffer ends without the end-of-packet marker, the block reads the next descriptor ahead of time. If that descriptor is not owned, or the FIFO runs dry before its contents arrive, the block records a buffer error together with an underflow. A control input decides what follows an underflow. The block either switches the transmitter off, or it scans forward through the ring, hands back descriptors that continue the broken frame, and resumes at the next start-of-frame descriptor.

Descriptor word layout (32 bits): [31] owned by controller, [30] start of frame, [29] end of packet, [28] buffer error, [27] underflow, [26] excessive deferral, [25] late collision, [24] lost carrier, [23] bus parity error, [22:16] reserved, [15:12] fixed ones field, [11:0] byte count.

Top module: `txdesc_err_ctrl`

## Requirements
- R1: After reset txon_o, rd_req_o, wr_en_o, xfer_o, exdef_irq_o and err_irq_o are all 0. While txon_o is 0 the block issues no reads and no writes. start_i sets txon_o and fetches the descriptor at the current ring index.
- R2: The byte count [11:0] encodes the buffer length as its two's complement modulo 4096, and 0 encodes 4096. The descriptor accepts exactly that many bytes, where a byte is accepted in a cycle with xfer_o=1, byte_i=1 and fifo_empty_i=0.
- R3: Every write-back clears bit 31 and keeps all other bits of the word as read, including [15:12], [11:0], [30] and [29]. Status bits [28:23] are only ORed in and are never cleared.
- R4: A fetched descriptor with bit 31 = 0 produces no write. The block waits without reading until poll_i, then reads the same index again.
- R5: When a buffer ends without bit 29 and the next descriptor is owned, the current descriptor is written back with no error bits. The frame then continues with the bytes of the next descriptor.
- R6: When a buffer ends without bit 29 and the next descriptor has bit 31 = 0, the current descriptor is written with both bit 28 and bit 27 set.
- R7: When fifo_empty_i is 1 during the lookahead read, before the next descriptor's data is returned, the current descriptor is written with both bit 28 and bit 27 set.
- R8: When fifo_empty_i is 1 while a buffer still has bytes to send, the frame is truncated and the descriptor is written with bit 27 set and bit 28 clear.
- R9: With uflo_recover_i = 0, txon_o falls in the cycle after an underflow write-back. The block then ignores poll_i and stays idle until start_i.
- R10: With uflo_recover_i = 1, txon_o stays 1 after an underflow. Owned descriptors without bit 30 are written back with only bit 31 cleared and send no bytes, and transmission resumes at the next owned descriptor with bit 30.
- R11: late_col_i during a buffer ends that buffer at once, writes bit 25, and moves to the next start-of-frame descriptor without retrying the frame.
- R12: ex_defer_i during a buffer sets bit 26 and raises exdef_irq_o for exactly the following cycle.
- R13: par_err_i sets bit 23 only when par_en_i = 1. lost_carrier_i sets bit 24.
- R14: err_irq_o pulses for one cycle after a write-back that carries underflow, buffer error or late collision, and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Turn the transmitter on and begin fetching |
| poll_i | input | 1 | Retry fetch after an unowned descriptor |
| uflo_recover_i | input | 1 | 1: skip to next frame after underflow; 0: stop |
| par_en_i | input | 1 | Enable reporting of bus parity errors |
| rd_req_o | output | 1 | Descriptor read request, held until rd_valid_i |
| rd_idx_o | output | IDX_W | Ring index to read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Descriptor word read |
| wr_en_o | output | 1 | Descriptor write strobe |
| wr_idx_o | output | IDX_W | Ring index to write |
| wr_data_o | output | 32 | Descriptor word written back |
| xfer_o | output | 1 | A buffer is open and accepts bytes |
| byte_i | input | 1 | Data path takes one byte |
| fifo_empty_i | input | 1 | Transmit FIFO has run dry |
| late_col_i | input | 1 | Collision after the first slot time |
| lost_carrier_i | input | 1 | Carrier lost during the frame |
| ex_defer_i | input | 1 | Excessive deferral event |
| par_err_i | input | 1 | Bus parity error on buffer data |
| txon_o | output | 1 | Transmitter enabled |
| exdef_irq_o | output | 1 | Excessive deferral interrupt pulse |
| err_irq_o | output | 1 | Frame error interrupt pulse |

## Verification
The length decode is checked across byte counts that cover a single byte, small and mid-sized buffers, 4095 bytes and the 4096 encoding of zero. These cases separate a correct negation from an off-by-one or from a missing top bit. Two-descriptor frames are run with the next descriptor owned, with it unowned, and with the FIFO draining during the lookahead. This shows a clean chain apart from both buffer-error causes. Underflow is driven once with the recovery bit set and once with it cleared, so that ring scanning can be told apart from shutdown. Late collision, deferral, lost carrier and parity events are injected at known byte positions, with parity reporting both off and on and a status bit already set in memory to exercise stickiness.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = 12;

  localparam int unsigned OWN_B  = 31;
  localparam int unsigned STP_B  = 30;
  localparam int unsigned ENP_B  = 29;
  localparam int unsigned BUF_B  = 28;
  localparam int unsigned UFLO_B = 27;
  localparam int unsigned EXD_B  = 26;
  localparam int unsigned LCOL_B = 25;
  localparam int unsigned LCAR_B = 24;
  localparam int unsigned PAR_B  = 23;

  typedef struct packed {
    logic buf_err;
    logic uflo;
    logic exdef;
    logic lcol;
    logic lcar;
    logic par;
  } err_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_POLL, ST_XFER, ST_LOOK, ST_WB
  } state_e;

  typedef enum logic [1:0] {
    NX_SEEK, NX_STOP, NX_CHAIN
  } nx_e;

  function automatic logic [WORD_W-1:0] merge_status(input logic [WORD_W-1:0] w,
                                                     input err_t e);
    logic [WORD_W-1:0] r;
    r         = w;
    r[OWN_B]  = 1'b0;
    r[BUF_B]  = w[BUF_B]  | e.buf_err;
    r[UFLO_B] = w[UFLO_B] | e.uflo;
    r[EXD_B]  = w[EXD_B]  | e.exdef;
    r[LCOL_B] = w[LCOL_B] | e.lcol;
    r[LCAR_B] = w[LCAR_B] | e.lcar;
    r[PAR_B]  = w[PAR_B]  | e.par;
    return r;
  endfunction
endpackage

// File: rtl/txd_len_cnt.sv
module txd_len_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] bcnt_i,
  input  logic             take_i,
  output logic             last_o
);
  localparam int unsigned REM_W = CNT_W + 1;

  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] neg;

  // two's complement length; zero wraps to the full 2^CNT_W
  assign neg    = ~bcnt_i + CNT_W'(1);
  assign last_o = (rem_q == REM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= {(bcnt_i == '0), neg};
    else if (take_i) rem_q <= rem_q - REM_W'(1);
  end
endmodule

// File: rtl/txd_err_acc.sv
module txd_err_acc
  import txd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  err_t set_i,
  output err_t flags_o
);
  err_t fix;
  err_t flags_q;

  always_comb begin
    fix      = set_i;
    fix.uflo = set_i.uflo | set_i.buf_err; // buffer error always carries underflow
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (clr_i) flags_q <= '0;
    else            flags_q <= err_t'(flags_q | fix);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/txdesc_err_ctrl.sv
module txdesc_err_ctrl
  import txd_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              poll_i,
  input  logic              uflo_recover_i,
  input  logic              par_en_i,
  output logic              rd_req_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [31:0]       wr_data_o,
  output logic              xfer_o,
  input  logic              byte_i,
  input  logic              fifo_empty_i,
  input  logic              late_col_i,
  input  logic              lost_carrier_i,
  input  logic              ex_defer_i,
  input  logic              par_err_i,
  output logic              txon_o,
  output logic              exdef_irq_o,
  output logic              err_irq_o
);
  state_e            st_q;
  nx_e               nx_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] cur_q, nxt_q, skip_word;
  logic              txon_q, exdef_irq_q, err_irq_q;

  logic in_xfer, in_look, in_wb;
  logic rd_own, rd_stp;
  logic take, last;
  logic fetch_go, fetch_skip, chain_go, cnt_load;
  logic [CNT_W-1:0] cnt_src;
  err_t ev, flags;
  nx_e  nx_uflo;

  assign in_xfer = (st_q == ST_XFER);
  assign in_look = (st_q == ST_LOOK);
  assign in_wb   = (st_q == ST_WB);
  assign rd_own  = rd_data_i[OWN_B];
  assign rd_stp  = rd_data_i[STP_B];

  assign take       = in_xfer && byte_i && !fifo_empty_i;
  assign fetch_go   = (st_q == ST_FETCH) && rd_valid_i && rd_own && rd_stp;
  assign fetch_skip = (st_q == ST_FETCH) && rd_valid_i && rd_own && !rd_stp;
  assign chain_go   = in_wb && (nx_q == NX_CHAIN);
  assign cnt_load   = fetch_go || chain_go;
  assign cnt_src    = fetch_go ? rd_data_i[CNT_W-1:0] : nxt_q[CNT_W-1:0];
  assign nx_uflo    = uflo_recover_i ? NX_SEEK : NX_STOP;

  txd_len_cnt #(.CNT_W(CNT_W)) i_len_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .bcnt_i (cnt_src),
    .take_i (take),
    .last_o (last)
  );

  always_comb begin
    ev = '0;
    if (in_xfer) begin
      ev.uflo  = fifo_empty_i;
      ev.lcol  = late_col_i;
      ev.lcar  = lost_carrier_i;
      ev.exdef = ex_defer_i;
      ev.par   = par_err_i && par_en_i;
    end else if (in_look) begin
      ev.buf_err = fifo_empty_i || (rd_valid_i && !rd_own);
    end
  end

  txd_err_acc i_err_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_load),
    .set_i   (ev),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      nx_q        <= NX_SEEK;
      idx_q       <= '0;
      cur_q       <= '0;
      nxt_q       <= '0;
      txon_q      <= 1'b0;
      exdef_irq_q <= 1'b0;
      err_irq_q   <= 1'b0;
    end else begin
      exdef_irq_q <= in_xfer && ex_defer_i;
      err_irq_q   <= in_wb && (flags.uflo || flags.buf_err || flags.lcol);
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          txon_q <= 1'b1;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: if (rd_valid_i) begin
          if (!rd_own)      st_q  <= ST_POLL;
          else if (!rd_stp) idx_q <= idx_q + IDX_W'(1);
          else begin
            cur_q <= rd_data_i;
            st_q  <= ST_XFER;
          end
        end
        ST_POLL: if (poll_i) st_q <= ST_FETCH;
        ST_XFER: begin
          if (fifo_empty_i) begin
            st_q <= ST_WB;
            nx_q <= nx_uflo;
          end else if (late_col_i) begin
            st_q <= ST_WB;
            nx_q <= NX_SEEK;
          end else if (take && last) begin
            if (cur_q[ENP_B]) begin
              st_q <= ST_WB;
              nx_q <= NX_SEEK;
            end else begin
              st_q <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (fifo_empty_i) begin
            st_q <= ST_WB;
            nx_q <= nx_uflo;
          end else if (rd_valid_i) begin
            st_q <= ST_WB;
            if (!rd_own) nx_q <= nx_uflo;
            else begin
              nxt_q <= rd_data_i;
              nx_q  <= NX_CHAIN;
            end
          end
        end
        ST_WB: begin
          idx_q <= idx_q + IDX_W'(1);
          unique case (nx_q)
            NX_STOP: begin
              txon_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
            NX_CHAIN: begin
              cur_q <= nxt_q;
              st_q  <= ST_XFER;
            end
            default: st_q <= ST_FETCH;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    skip_word        = rd_data_i;
    skip_word[OWN_B] = 1'b0;
  end

  assign rd_req_o    = (st_q == ST_FETCH) || in_look;
  assign rd_idx_o    = in_look ? idx_q + IDX_W'(1) : idx_q;
  assign wr_en_o     = in_wb || fetch_skip;
  assign wr_idx_o    = idx_q;
  assign wr_data_o   = in_wb ? merge_status(cur_q, flags) : skip_word;
  assign xfer_o      = in_xfer;
  assign txon_o      = txon_q;
  assign exdef_irq_o = exdef_irq_q;
  assign err_irq_o   = err_irq_q;
endmodule

// File: rtl/txdesc_err_ctrl_chk.sv
module txdesc_err_ctrl_chk #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             uflo_recover_i,
  input logic             rd_req_o,
  input logic             wr_en_o,
  input logic [31:0]      wr_data_o,
  input logic             xfer_o,
  input logic             ex_defer_i,
  input logic             txon_o,
  input logic             exdef_irq_o
);
  assert_wb_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wr_data_o[31]);

  assert_buf_has_uflo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_data_o[28]) |-> wr_data_o[27]);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txon_o |-> (!rd_req_o && !wr_en_o && !xfer_o));

  assert_stop_after_wb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txon_o) |-> $past(wr_en_o));

  assert_recover_keeps_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txon_o && wr_en_o && !rd_req_o && uflo_recover_i) |=> txon_o);

  assert_exdef_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exdef_irq_o |-> ($past(ex_defer_i) && $past(xfer_o)));
endmodule

bind txdesc_err_ctrl txdesc_err_ctrl_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_txdesc_err_ctrl.sv
`timescale 1ns/1ps
module test_txdesc_err_ctrl;
  localparam int IDX_W = 3;
  localparam int RING  = 1 << IDX_W;
  localparam logic [31:0] B_BUF = 32'h1000_0000, B_UFLO = 32'h0800_0000,
    B_EXD = 32'h0400_0000, B_LCOL = 32'h0200_0000, B_LCAR = 32'h0100_0000,
    B_PAR = 32'h0080_0000;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC_BCNT [NVEC] = '{12'hFFF, 12'hFFE, 12'hF00, 12'h800, 12'h001, 12'h000};
  localparam int          VEC_LEN  [NVEC] = '{1, 2, 256, 2048, 4095, 4096};

  logic clk = 0, rst_n = 0;
  logic start = 0, poll = 0, recover = 1, par_en = 0;
  logic rd_req, rd_valid = 0, wr_en, xfer, byte_in = 1, fifo_empty = 0;
  logic late_col = 0, lost_car = 0, ex_defer = 0, par_err = 0;
  logic txon, exdef_irq, err_irq;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [31:0] rd_data = '0, wr_data;
  logic [31:0] mem [RING];
  int wr_cnt = 0, byte_cnt = 0, err_cnt = 0, exd_cnt = 0, rd_cnt = 0;
  int checks = 0, fails = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  txdesc_err_ctrl #(.IDX_W(IDX_W)) i_txdesc_err_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .poll_i(poll),
    .uflo_recover_i(recover), .par_en_i(par_en), .rd_req_o(rd_req), .rd_idx_o(rd_idx),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .xfer_o(xfer), .byte_i(byte_in), .fifo_empty_i(fifo_empty),
    .late_col_i(late_col), .lost_carrier_i(lost_car), .ex_defer_i(ex_defer),
    .par_err_i(par_err), .txon_o(txon), .exdef_irq_o(exdef_irq), .err_irq_o(err_irq));

  // descriptor memory and event counters
  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= mem[rd_idx];
    if (rd_req && !rd_valid) rd_cnt <= rd_cnt + 1;
    if (xfer && byte_in && !fifo_empty) byte_cnt <= byte_cnt + 1;
    if (err_irq) err_cnt <= err_cnt + 1;
    if (exdef_irq) exd_cnt <= exd_cnt + 1;
  end

  function automatic logic [31:0] desc(input logic own, stp, enp, input logic [11:0] bc);
    return {own, stp, enp, 13'b0, 4'hF, bc};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_wr(input int target);
    int t = 0;
    while (wr_cnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk("wait_wr timeout", 32'(wr_cnt), 32'(target));
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wait_xfer();
    int t = 0;
    do begin @(negedge clk); t++; end while (!xfer && t < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0, b0, e0, r0;
    for (int i = 0; i < RING; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 txon", 32'(txon), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 wr_en", 32'(wr_en), 0);
    chk("R1 irqs", {30'b0, exdef_irq, err_irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 unowned descriptor: no write, wait for poll
    pulse(start);
    repeat (6) @(negedge clk);
    chk("R1 txon after start", 32'(txon), 1);
    chk("R4 no write", 32'(wr_cnt), 0);
    chk("R4 no read while polling", 32'(rd_req), 0);

    // R2/R3 length decode table
    for (int v = 0; v < NVEC; v++) begin
      w0 = wr_cnt; b0 = byte_cnt;
      mem[v] = desc(1, 1, 1, VEC_BCNT[v]);
      pulse(poll);
      wait_wr(w0 + 1);
      repeat (8) @(negedge clk);
      chk($sformatf("R2 bytes vec%0d", v), 32'(byte_cnt - b0), 32'(VEC_LEN[v]));
      chk($sformatf("R3 word vec%0d", v), mem[v], desc(0, 1, 1, VEC_BCNT[v]));
    end
    chk("R4 writes in table", 32'(wr_cnt), NVEC);

    // R5 chain of two owned descriptors
    w0 = wr_cnt; b0 = byte_cnt; e0 = err_cnt;
    mem[6] = desc(1, 1, 0, 12'hFFE);
    mem[7] = desc(1, 0, 1, 12'hFFD);
    pulse(poll);
    wait_wr(w0 + 2);
    repeat (8) @(negedge clk);
    chk("R5 first word", mem[6], desc(0, 1, 0, 12'hFFE));
    chk("R5 second word", mem[7], desc(0, 0, 1, 12'hFFD));
    chk("R5 bytes", 32'(byte_cnt - b0), 5);
    chk("R14 no irq on clean chain", 32'(err_cnt - e0), 0);

    // R6 next descriptor not owned
    w0 = wr_cnt; e0 = err_cnt;
    mem[0] = desc(1, 1, 0, 12'hFFF);
    pulse(poll);
    wait_wr(w0 + 1);
    repeat (8) @(negedge clk);
    chk("R6 buf+uflo", mem[0], desc(0, 1, 0, 12'hFFF) | B_BUF | B_UFLO);
    chk("R14 irq on buf error", 32'(err_cnt - e0), 1);
    chk("R10 txon kept", 32'(txon), 1);

    // R7 FIFO dry during lookahead; R10 skip of continuation
    w0 = wr_cnt; b0 = byte_cnt;
    mem[1] = desc(1, 1, 0, 12'hFFF);
    mem[2] = desc(1, 0, 1, 12'hFFF);
    pulse(poll);
    wait_xfer();
    while (xfer) @(negedge clk);
    fifo_empty = 1;
    wait_wr(w0 + 1);
    fifo_empty = 0;
    wait_wr(w0 + 2);
    repeat (8) @(negedge clk);
    chk("R7 buf+uflo", mem[1], desc(0, 1, 0, 12'hFFF) | B_BUF | B_UFLO);
    chk("R10 continuation released", mem[2], desc(0, 0, 1, 12'hFFF));
    chk("R7 bytes", 32'(byte_cnt - b0), 1);

    // R8 underflow inside buffer; R10 resume at next start of frame
    w0 = wr_cnt; b0 = byte_cnt;
    mem[3] = desc(1, 1, 1, 12'hFFC);
    mem[4] = desc(1, 0, 1, 12'hFFE);
    mem[5] = desc(1, 1, 1, 12'hFFE);
    pulse(poll);
    wait_xfer();
    fifo_empty = 1;
    wait_wr(w0 + 1);
    fifo_empty = 0;
    wait_wr(w0 + 3);
    repeat (8) @(negedge clk);
    chk("R8 uflo only", mem[3], desc(0, 1, 1, 12'hFFC) | B_UFLO);
    chk("R10 skipped word", mem[4], desc(0, 0, 1, 12'hFFE));
    chk("R10 resumed frame", mem[5], desc(0, 1, 1, 12'hFFE));
    chk("R10 resumed bytes", 32'(byte_cnt - b0), 2);
    chk("R10 txon", 32'(txon), 1);

    // R9 underflow with recovery off
    recover = 0;
    w0 = wr_cnt;
    mem[6] = desc(1, 1, 1, 12'hFFE);
    pulse(poll);
    wait_xfer();
    fifo_empty = 1;
    wait_wr(w0 + 1);
    chk("R9 txon off", 32'(txon), 0);
    fifo_empty = 0;
    r0 = rd_cnt;
    pulse(poll);
    repeat (6) @(negedge clk);
    chk("R9 poll ignored reads", 32'(rd_cnt - r0), 0);
    chk("R9 poll ignored writes", 32'(wr_cnt - w0), 1);
    chk("R8 uflo word", mem[6], desc(0, 1, 1, 12'hFFE) | B_UFLO);
    recover = 1;

    // R11 late collision
    w0 = wr_cnt; b0 = byte_cnt; e0 = err_cnt;
    mem[7] = desc(1, 1, 1, 12'hFF0);
    mem[0] = desc(1, 0, 1, 12'hFFE);
    pulse(start);
    wait_xfer();
    @(negedge clk);
    @(negedge clk); late_col = 1;
    @(negedge clk); late_col = 0;
    wait_wr(w0 + 2);
    repeat (8) @(negedge clk);
    chk("R11 lcol word", mem[7], desc(0, 1, 1, 12'hFF0) | B_LCOL);
    chk("R11 truncated bytes", 32'(byte_cnt - b0), 3);
    chk("R11 no retry", mem[0], desc(0, 0, 1, 12'hFFE));
    chk("R14 irq on lcol", 32'(err_cnt - e0), 1);

    // R12/R13 deferral, parity disabled, lost carrier
    w0 = wr_cnt; e0 = err_cnt;
    par_en = 0;
    mem[1] = desc(1, 1, 1, 12'hFF8);
    pulse(poll);
    wait_xfer();
    @(negedge clk); ex_defer = 1;
    @(negedge clk); ex_defer = 0; par_err = 1;
    chk("R12 irq high", 32'(exdef_irq), 1);
    @(negedge clk); par_err = 0; lost_car = 1;
    chk("R12 irq one cycle", 32'(exdef_irq), 0);
    @(negedge clk); lost_car = 0;
    wait_wr(w0 + 1);
    repeat (8) @(negedge clk);
    chk("R13 no parity when off", mem[1], desc(0, 1, 1, 12'hFF8) | B_EXD | B_LCAR);
    chk("R12 irq count", 32'(exd_cnt), 1);

    // R13 parity enabled, R3 sticky preset bit
    w0 = wr_cnt;
    par_en = 1;
    mem[2] = desc(1, 1, 1, 12'hFF8) | B_LCAR;
    pulse(poll);
    wait_xfer();
    @(negedge clk); par_err = 1;
    @(negedge clk); par_err = 0;
    wait_wr(w0 + 1);
    repeat (8) @(negedge clk);
    chk("R13 parity set; R3 sticky", mem[2], desc(0, 1, 1, 12'hFF8) | B_LCAR | B_PAR);
    chk("R14 no irq for status only", 32'(err_cnt - e0), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule